// File: doc/BRIEF.md
# Addressed Stream Port Array

This block is a WISHBONE slave that gives a host a set of streaming ports, one fixed bus address per port. The number of ports is a power of two set by a parameter. Each bus write to a port's data address pushes one word into that port's outgoing FIFO. That FIFO drives a valid/ready stream into a processing block. Each bus read from a port's data address pops one word from that port's incoming FIFO, which is filled by a processing block's result stream. A host moves a block of stream data by repeating accesses to the same address.

When a FIFO cannot take or give a word, the bus cycle is stalled by holding back the acknowledge. If the stall lasts for a bounded number of cycles, the access is refused with an error. A second address window gives one status word per port. It reports both fill levels and two sticky flags that record refused writes and refused reads.

Top module: `fifo_port_array`

## Requirements
- R1: Byte address bits [1:0] are ignored. Bits [PORT_BITS+1:2] select the port. Bit PORT_BITS+2 picks the data window (0) or the status window (1). Higher bits are ignored. With the defaults, port bits are [3:2] and the window bit is bit 4.
- R2: A data-window write to port p with free space pushes the word into p's outgoing FIFO and is acknowledged. The words leave on p's outgoing stream in write order, and no other port's stream changes.
- R3: A data-window read from port p with a non-empty incoming FIFO is acknowledged with the oldest word received on p's incoming stream, and that word is removed.
- R4: A write to a full outgoing FIFO is not acknowledged while the FIFO stays full. If a slot frees before the timeout, the write completes with an acknowledge and the word is queued.
- R5: After TIMEOUT consecutive stalled cycles, a write to a full FIFO ends with ERR exactly TIMEOUT cycles after it was presented. The word is dropped, and the port's overflow flag (status bit 16) is set.
- R6: A read from an empty incoming FIFO is stalled in the same way. After TIMEOUT cycles it ends with ERR, pops nothing, and sets the port's underflow flag (status bit 17).
- R7: A status-window read returns the outgoing fill level in bits [2:0] and the incoming fill level in bits [10:8] (with the default depth). It returns the overflow flag in bit 16 and the underflow flag in bit 17. All other bits are 0.
- R8: Both flags stay set until a status-window write with a 1 in that flag's bit position clears it. A 0 in that bit leaves the flag unchanged.
- R9: While an outgoing stream has valid high and ready low, its valid stays high and its data does not change.
- R10: After reset all FIFOs are empty, no outgoing valid is raised, every incoming ready is high, and all flags are clear. Incoming ready is low while that FIFO is full, and a word offered then is not stored.
- R11: Each access ends with exactly one single-cycle pulse of ACK or ERR, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid with ACK |
| wb_ack_o | output | 1 | Access completed |
| wb_err_o | output | 1 | Access refused after timeout |
| tx_valid_o | output | 2^PORT_BITS | Per-port outgoing stream valid |
| tx_ready_i | input | 2^PORT_BITS | Per-port outgoing stream ready |
| tx_data_o | output | 2^PORT_BITS*DATA_W | Outgoing stream data, port i in slice i |
| rx_valid_i | input | 2^PORT_BITS | Per-port incoming stream valid |
| rx_ready_o | output | 2^PORT_BITS | Per-port incoming stream ready |
| rx_data_i | input | 2^PORT_BITS*DATA_W | Incoming stream data, port i in slice i |

## Verification
The main push and pop paths are driven by a seeded random mix of writes, incoming stream words, reads, single-word drains and status reads on random ports with random byte offsets. This shows that port selection, ordering and level counting hold under interleaving, and that no word leaks between ports. Directed cases then fill a FIFO and release one slot in the middle of a stall, to separate the late-acknowledge path from the timeout path. They also let writes and reads time out, to check the exact ERR cycle and the flags set. Writes to the status window carry 0 and then 1 in each flag bit, to show that clearing is per bit. Finally an incoming FIFO is pushed past full, to show that words offered while ready is low are dropped.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
package fpa_pkg;
    localparam int WORD_OFS_BITS = 2;
    localparam int STAT_RX_LSB   = 8;
    localparam int STAT_OVF_BIT  = 16;
    localparam int STAT_UNF_BIT  = 17;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_STATUS,
        ACC_PUSH,
        ACC_POP
    } acc_e;
endpackage

// File: rtl/fpa_fifo.sv
`timescale 1ns/1ps
module fpa_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic                          pop_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic                          full_o,
    output logic                          empty_o,
    output logic [$clog2(DEPTH+1)-1:0]    level_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LVL_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t          st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wr = (st_q.wr == PTR_W'(DEPTH-1)) ? '0 : st_q.wr + PTR_W'(1);
        if (pop_i)  st_d.rd = (st_q.rd == PTR_W'(DEPTH-1)) ? '0 : st_q.rd + PTR_W'(1);
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + LVL_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - LVL_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[st_q.wr] <= wdata_i;
    end

    assign rdata_o = mem[st_q.rd];
    assign full_o  = (st_q.cnt == LVL_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign level_o = st_q.cnt;

    // R4: the bus side never pushes into a full FIFO
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R6: the bus side never pops an empty FIFO
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/fpa_lane.sv
`timescale 1ns/1ps
module fpa_lane #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_push_i,
    input  logic [DATA_W-1:0]             bus_wdata_i,
    input  logic                          bus_pop_i,
    output logic [DATA_W-1:0]             bus_rdata_o,
    output logic                          tx_full_o,
    output logic                          rx_empty_o,
    output logic [$clog2(DEPTH+1)-1:0]    tx_level_o,
    output logic [$clog2(DEPTH+1)-1:0]    rx_level_o,
    output logic                          tx_valid_o,
    input  logic                          tx_ready_i,
    output logic [DATA_W-1:0]             tx_data_o,
    input  logic                          rx_valid_i,
    output logic                          rx_ready_o,
    input  logic [DATA_W-1:0]             rx_data_i
);
    logic tx_empty, rx_full;

    fpa_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .push_i(bus_push_i), .wdata_i(bus_wdata_i),
        .pop_i(tx_valid_o && tx_ready_i), .rdata_o(tx_data_o),
        .full_o(tx_full_o), .empty_o(tx_empty), .level_o(tx_level_o)
    );

    fpa_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_valid_i && rx_ready_o), .wdata_i(rx_data_i),
        .pop_i(bus_pop_i), .rdata_o(bus_rdata_o),
        .full_o(rx_full), .empty_o(rx_empty_o), .level_o(rx_level_o)
    );

    assign tx_valid_o = !tx_empty;
    assign rx_ready_o = !rx_full;

    // R9: a stalled outgoing word stays presented and unchanged
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/fifo_port_array.sv
`timescale 1ns/1ps
module fifo_port_array
    import fpa_pkg::*;
#(
    parameter int PORT_BITS = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int DEPTH     = 4,
    parameter int TIMEOUT   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wb_cyc_i,
    input  logic                              wb_stb_i,
    input  logic                              wb_we_i,
    input  logic [ADDR_W-1:0]                 wb_adr_i,
    input  logic [DATA_W-1:0]                 wb_dat_i,
    output logic [DATA_W-1:0]                 wb_dat_o,
    output logic                              wb_ack_o,
    output logic                              wb_err_o,
    output logic [(1<<PORT_BITS)-1:0]         tx_valid_o,
    input  logic [(1<<PORT_BITS)-1:0]         tx_ready_i,
    output logic [(1<<PORT_BITS)*DATA_W-1:0]  tx_data_o,
    input  logic [(1<<PORT_BITS)-1:0]         rx_valid_i,
    output logic [(1<<PORT_BITS)-1:0]         rx_ready_o,
    input  logic [(1<<PORT_BITS)*DATA_W-1:0]  rx_data_i
);
    localparam int NPORT  = 1 << PORT_BITS;
    localparam int LVL_W  = $clog2(DEPTH+1);
    localparam int WAIT_W = $clog2(TIMEOUT+1);
    localparam int WIN_BIT = WORD_OFS_BITS + PORT_BITS;

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] dat;
        logic [WAIT_W-1:0] wait_cnt;
        logic [NPORT-1:0]  ovf;
        logic [NPORT-1:0]  unf;
    } bus_st_t;

    bus_st_t st_d, st_q;

    logic [PORT_BITS-1:0] port_sel;
    logic                 stat_sel;
    logic                 req;
    acc_e                 acc;
    logic [NPORT-1:0]     push_v, pop_v, tx_full, rx_empty;
    logic [DATA_W-1:0]    rx_head [NPORT];
    logic [LVL_W-1:0]     tx_lvl  [NPORT];
    logic [LVL_W-1:0]     rx_lvl  [NPORT];
    logic [DATA_W-1:0]    stat_word;
    logic                 stalled;
    logic                 unused_adr;

    assign port_sel   = wb_adr_i[WORD_OFS_BITS +: PORT_BITS];
    assign stat_sel   = wb_adr_i[WIN_BIT];
    assign unused_adr = ^{wb_adr_i[WORD_OFS_BITS-1:0], wb_adr_i[ADDR_W-1:WIN_BIT+1]};
    assign req        = wb_cyc_i && wb_stb_i && !st_q.ack && !st_q.err;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_lane
            fpa_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .bus_push_i(push_v[i]), .bus_wdata_i(wb_dat_i),
                .bus_pop_i(pop_v[i]), .bus_rdata_o(rx_head[i]),
                .tx_full_o(tx_full[i]), .rx_empty_o(rx_empty[i]),
                .tx_level_o(tx_lvl[i]), .rx_level_o(rx_lvl[i]),
                .tx_valid_o(tx_valid_o[i]), .tx_ready_i(tx_ready_i[i]),
                .tx_data_o(tx_data_o[i*DATA_W +: DATA_W]),
                .rx_valid_i(rx_valid_i[i]), .rx_ready_o(rx_ready_o[i]),
                .rx_data_i(rx_data_i[i*DATA_W +: DATA_W])
            );

            // R8: a flag only drops on a bus write
            p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(st_q.ovf[i]) || $fell(st_q.unf[i])) |->
                $past(wb_cyc_i && wb_stb_i && wb_we_i));
        end
    endgenerate

    always_comb begin
        stat_word = '0;
        stat_word[LVL_W-1:0]              = tx_lvl[port_sel];
        stat_word[STAT_RX_LSB +: LVL_W]   = rx_lvl[port_sel];
        stat_word[STAT_OVF_BIT]           = st_q.ovf[port_sel];
        stat_word[STAT_UNF_BIT]           = st_q.unf[port_sel];
    end

    always_comb begin
        acc = ACC_IDLE;
        if (req) acc = stat_sel ? ACC_STATUS : (wb_we_i ? ACC_PUSH : ACC_POP);
    end

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.err = 1'b0;
        push_v   = '0;
        pop_v    = '0;
        stalled  = 1'b0;
        case (acc)
            ACC_STATUS: begin
                st_d.ack = 1'b1;
                if (wb_we_i) begin
                    if (wb_dat_i[STAT_OVF_BIT]) st_d.ovf[port_sel] = 1'b0;
                    if (wb_dat_i[STAT_UNF_BIT]) st_d.unf[port_sel] = 1'b0;
                end else begin
                    st_d.dat = stat_word;
                end
            end
            ACC_PUSH: begin
                if (!tx_full[port_sel]) begin
                    push_v[port_sel] = 1'b1;
                    st_d.ack         = 1'b1;
                end else begin
                    stalled = 1'b1;
                end
            end
            ACC_POP: begin
                if (!rx_empty[port_sel]) begin
                    pop_v[port_sel] = 1'b1;
                    st_d.dat        = rx_head[port_sel];
                    st_d.ack        = 1'b1;
                end else begin
                    stalled = 1'b1;
                end
            end
            default: ;
        endcase

        if (!stalled) begin
            st_d.wait_cnt = '0;
        end else if (st_q.wait_cnt == WAIT_W'(TIMEOUT-1)) begin
            st_d.wait_cnt = '0;
            st_d.err      = 1'b1;
            if (wb_we_i) st_d.ovf[port_sel] = 1'b1;
            else         st_d.unf[port_sel] = 1'b1;
        end else begin
            st_d.wait_cnt = st_q.wait_cnt + WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_ack_o = st_q.ack;
    assign wb_err_o = st_q.err;
    assign wb_dat_o = st_q.dat;

    // R11: never both terminations together
    p_ack_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_ack_o && wb_err_o));
    // R11: a termination lasts one cycle
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o || wb_err_o) |=> !(wb_ack_o || wb_err_o));
    // R5: an error only answers a presented access
    p_err_on_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err_o |-> $past(wb_cyc_i && wb_stb_i));
endmodule

// File: tb/tb_fifo_port_array.sv
`timescale 1ns/1ps
module tb_fifo_port_array;
    localparam int NP = 4;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int TIMEOUT = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic cyc = 0, stb = 0, we = 0;
    logic [7:0] adr = '0;
    logic [DW-1:0] dat_w = '0;
    logic [DW-1:0] dat_r;
    logic ack, err;
    logic [NP-1:0] tx_valid, rx_ready;
    logic [NP-1:0] tx_ready = '0, rx_valid = '0;
    logic [NP*DW-1:0] tx_data;
    logic [NP*DW-1:0] rx_data = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [DW-1:0] txm [NP][DEPTH];
    logic [DW-1:0] rxm [NP][DEPTH];
    int txc [NP];
    int rxc [NP];
    bit ovf_m [NP];
    bit unf_m [NP];

    fifo_port_array dut (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_dat_i(dat_w), .wb_dat_o(dat_r), .wb_ack_o(ack), .wb_err_o(err),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
        .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] data_addr(input int p);
        return 8'((p << 2) | int'($urandom_range(0, 3)));
    endfunction

    function automatic logic [7:0] stat_addr(input int p);
        return 8'(16 | (p << 2));
    endfunction

    function automatic logic [DW-1:0] exp_stat(input int p);
        logic [DW-1:0] s;
        s = '0;
        s[2:0]  = 3'(txc[p]);
        s[10:8] = 3'(rxc[p]);
        s[16]   = ovf_m[p];
        s[17]   = unf_m[p];
        return s;
    endfunction

    task automatic bus(input logic w, input logic [7:0] a, input logic [DW-1:0] d,
                       input int rel_port, input int rel_at,
                       output logic [DW-1:0] rd, output bit got_ack, output bit got_err, output int ncyc);
        cyc = 1; stb = 1; we = w; adr = a; dat_w = d;
        ncyc = 0; got_ack = 0; got_err = 0; rd = '0;
        while (!(got_ack || got_err) && ncyc < 100) begin
            @(posedge clk); #1;
            ncyc++;
            if (rel_port >= 0) tx_ready[rel_port] = (ncyc == rel_at);
            if (ack || err) begin
                got_ack = ack; got_err = err; rd = dat_r;
                chk(!(ack && err), "R11 both", {30'b0, ack, err}, 32'h0);
            end
        end
        cyc = 0; stb = 0; we = 0;
        if (rel_port >= 0) tx_ready[rel_port] = 0;
        @(posedge clk); #1;
        chk(!(ack || err), "R11 pulse", {30'b0, ack, err}, 32'h0);
    endtask

    task automatic do_write(input int p, input logic [DW-1:0] d, input string tag);
        logic [DW-1:0] rd; bit a, e; int n;
        bus(1, data_addr(p), d, -1, 0, rd, a, e, n);
        chk(a && !e, tag, {30'b0, a, e}, 32'h2);
        txm[p][txc[p]] = d; txc[p]++;
    endtask

    task automatic do_read(input int p, input string tag);
        logic [DW-1:0] rd; bit a, e; int n;
        bus(0, data_addr(p), '0, -1, 0, rd, a, e, n);
        chk(a && rd == rxm[p][0], tag, rd, rxm[p][0]);
        for (int k = 0; k < DEPTH-1; k++) rxm[p][k] = rxm[p][k+1];
        rxc[p]--;
    endtask

    task automatic do_stat(input int p, input string tag);
        logic [DW-1:0] rd; bit a, e; int n;
        bus(0, stat_addr(p), '0, -1, 0, rd, a, e, n);
        chk(a && rd == exp_stat(p), tag, rd, exp_stat(p));
    endtask

    task automatic rx_push(input int p, input logic [DW-1:0] d, input string tag);
        chk(rx_ready[p] == 1'b1, tag, {31'b0, rx_ready[p]}, 32'h1);
        rx_valid[p] = 1; rx_data[p*DW +: DW] = d;
        @(posedge clk); #1;
        rx_valid[p] = 0;
        rxm[p][rxc[p]] = d; rxc[p]++;
    endtask

    task automatic drain_one(input int p, input string tag);
        chk(tx_valid[p] && tx_data[p*DW +: DW] == txm[p][0], tag, tx_data[p*DW +: DW], txm[p][0]);
        tx_ready[p] = 1;
        @(posedge clk); #1;
        tx_ready[p] = 0;
        for (int k = 0; k < DEPTH-1; k++) txm[p][k] = txm[p][k+1];
        txc[p]--;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd; bit a, e; int n;
        void'($urandom(32'h5eed));
        for (int p = 0; p < NP; p++) begin txc[p] = 0; rxc[p] = 0; ovf_m[p] = 0; unf_m[p] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R10 reset state
        chk(tx_valid == '0, "R10 tx_valid after reset", {28'b0, tx_valid}, 32'h0);
        chk(rx_ready == '1, "R10 rx_ready after reset", {28'b0, rx_ready}, 32'hf);
        for (int p = 0; p < NP; p++) do_stat(p, "R10 R7 status after reset");

        // R1 R2 R3 R7 random mix
        for (int it = 0; it < 300; it++) begin
            int p, op;
            p = int'($urandom_range(0, NP-1));
            op = int'($urandom_range(0, 4));
            case (op)
                0: if (txc[p] < DEPTH) do_write(p, $urandom, "R1 R2 random write");
                1: if (rxc[p] < DEPTH) rx_push(p, $urandom, "R10 rx_ready random");
                2: if (rxc[p] > 0) do_read(p, "R1 R3 random read order");
                3: if (txc[p] > 0) drain_one(p, "R2 stream order");
                default: do_stat(p, "R7 random status");
            endcase
        end
        for (int p = 0; p < NP; p++) begin
            while (txc[p] > 0) drain_one(p, "R2 final drain");
            while (rxc[p] > 0) do_read(p, "R3 final read");
        end
        chk(tx_valid == '0, "R2 all drained", {28'b0, tx_valid}, 32'h0);

        // R9 hold under backpressure
        do_write(3, 32'hA5A5_0001, "R2 write for hold");
        do_write(3, 32'hA5A5_0002, "R2 write for hold");
        repeat (5) begin
            @(posedge clk); #1;
            chk(tx_valid[3] && tx_data[3*DW +: DW] == 32'hA5A5_0001, "R9 hold", tx_data[3*DW +: DW], 32'hA5A5_0001);
        end
        chk(tx_valid[2:0] == 3'b000, "R2 other ports idle", {29'b0, tx_valid[2:0]}, 32'h0);
        drain_one(3, "R9 drain"); drain_one(3, "R9 drain");

        // R4 stall then release one slot
        for (int k = 0; k < DEPTH; k++) do_write(1, 32'h1000 + k, "R4 fill");
        bus(1, data_addr(1), 32'h1BAD, 1, 5, rd, a, e, n);
        chk(a && !e && n == 7, "R4 late ack cycle", n, 7);
        for (int k = 0; k < DEPTH-1; k++) txm[1][k] = txm[1][k+1];
        txm[1][DEPTH-1] = 32'h1BAD;
        do_stat(1, "R4 R7 full after late ack");

        // R5 timeout on full write
        bus(1, data_addr(1), 32'hDEAD, -1, 0, rd, a, e, n);
        chk(e && !a && n == TIMEOUT, "R5 err cycle", n, TIMEOUT);
        ovf_m[1] = 1;
        do_stat(1, "R5 ovf set, level unchanged");
        do_stat(0, "R5 other port flags clear");
        while (txc[1] > 0) drain_one(1, "R5 word dropped, order kept");

        // R6 timeout on empty read
        bus(0, data_addr(2), '0, -1, 0, rd, a, e, n);
        chk(e && !a && n == TIMEOUT, "R6 err cycle", n, TIMEOUT);
        unf_m[2] = 1;
        do_stat(2, "R6 unf set");
        rx_push(2, 32'h2222, "R6 push after");
        do_read(2, "R6 nothing popped by refused read");

        // R8 clear semantics
        bus(1, stat_addr(1), 32'h0, -1, 0, rd, a, e, n);
        do_stat(1, "R8 zero write keeps flag");
        bus(1, stat_addr(1), 32'h0002_0000, -1, 0, rd, a, e, n);
        do_stat(1, "R8 other bit keeps ovf");
        bus(1, stat_addr(1), 32'h0001_0000, -1, 0, rd, a, e, n);
        ovf_m[1] = 0;
        do_stat(1, "R8 ovf cleared");
        bus(1, stat_addr(2), 32'h0002_0000, -1, 0, rd, a, e, n);
        unf_m[2] = 0;
        do_stat(2, "R8 unf cleared");

        // R10 incoming full
        for (int k = 0; k < DEPTH; k++) rx_push(0, 32'h3000 + k, "R10 fill rx");
        chk(rx_ready[0] == 1'b0, "R10 rx_ready low when full", {31'b0, rx_ready[0]}, 32'h0);
        rx_valid[0] = 1; rx_data[DW-1:0] = 32'hBEEF;
        repeat (2) @(posedge clk);
        #1 rx_valid[0] = 0;
        do_stat(0, "R10 extra word ignored");
        while (rxc[0] > 0) do_read(0, "R10 R3 contents after overfill");
        do_stat(0, "R10 empty at end");

        finish_run();
    end
endmodule